// File: doc/BRIEF.md
# Serial binary-to-thermometer converter

This block turns an unsigned binary value of `VAL_W` bits into a thermometer word of `2^VAL_W - 1` bits. It does not decode in parallel. A start strobe loads a down-counter with the value and clears a shift register. Then, on every clock cycle while the count is non-zero, one '1' enters the low end of the shift register and the counter steps down by one. A value of k therefore takes k cycles of work and ends with exactly the k lowest bits set.

A busy flag covers the counting cycles. A one-cycle done pulse marks the cycle in which busy drops. The finished word stays on the output until another start is accepted. A start that arrives during a conversion is dropped. A start in the done cycle is accepted, so conversions can run back to back. A zero value needs no counting: done rises in the cycle after start and the word stays all zeros. The block has a synchronous, active-low reset.

Top module: `thq_conv`

## Requirements
- R1: The output word is `2^VAL_W - 1` bits wide. When done is high after a conversion of value k, bits [k-1:0] are 1 and every higher bit is 0.
- R2: A start sampled while busy is low is accepted. In the same clock edge it loads the value and clears the output word to all zeros. For a non-zero value, busy is high in the next cycle and the word reads zero.
- R3: In each cycle busy is high, the next cycle's word equals the current word shifted left by one with a 1 entering bit 0.
- R4: For a value k > 0, busy stays high for exactly k consecutive cycles after the accepted start.
- R5: Done is high for one cycle only: the first cycle in which busy is low after a conversion. Busy and done are never high together.
- R6: A zero value sets done in the cycle after the accepted start, never raises busy, and leaves the word all zeros.
- R7: A start sampled while busy is high has no effect. The running conversion keeps its value, its word and its timing.
- R8: While busy is low and no start is sampled, the output word holds its value.
- R9: A synchronous active-low reset clears the counter, the output word, busy and done at the next clock edge.
- R10: A start sampled in the done cycle is accepted like any other start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; captures value_i when not busy |
| value_i | input | VAL_W | Unsigned binary value to convert |
| busy_o | output | 1 | High while the counter is running |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |
| therm_o | output | 2^VAL_W-1 | Thermometer word |

## Verification
Two functions can meet in one cycle: the completion of a conversion, which drops busy and raises done, and the acceptance of a new start. The bench raises start in the exact cycle it sees done, sometimes with a zero value, so that a second done follows at once. It expects the new value to load, the word to clear and the new conversion to have its own full latency. A second collision is a start raised while busy is high. There the bench expects the running conversion to finish with its original word and cycle count, as if no start had arrived.

// File: rtl/thq_pkg.sv
package thq_pkg;

    // control state shared by the sequencing logic
    typedef struct packed {
        logic busy;
        logic done;
    } thq_ctl_t;

    function automatic int unsigned thq_word_width(input int unsigned val_w);
        return (32'd1 << val_w) - 32'd1;
    endfunction

endpackage

// File: rtl/thq_count.sv
module thq_count #(
    parameter int unsigned VAL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [VAL_W-1:0] value_i,
    output logic             last_o
);

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = value_i;
        end else if (step_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.cnt == ONE);

endmodule

// File: rtl/thq_shreg.sv
module thq_shreg #(
    parameter int unsigned WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [WORD_W-1:0] shifted;

    generate
        if (WORD_W == 1) begin : g_single
            assign shifted = 1'b1;
        end else begin : g_multi
            assign shifted = {st_q.word[WORD_W-2:0], 1'b1};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.word = '0;
        end else if (step_i) begin
            st_d.word = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/thq_ctrl.sv
module thq_ctrl
    import thq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_i,
    input  logic last_i,
    output logic load_o,
    output logic busy_o,
    output logic done_o
);

    thq_ctl_t ctl_d, ctl_q;
    logic     accept;

    // a start is taken only when no conversion is running
    assign accept = start_i && !ctl_q.busy;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) begin
            ctl_d.busy = !zero_i;
            ctl_d.done = zero_i;
        end else if (ctl_q.busy && last_i) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_o = accept;
    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;

endmodule

// File: rtl/thq_conv.sv
module thq_conv #(
    parameter int unsigned VAL_W = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [VAL_W-1:0]                     value_i,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic [thq_pkg::thq_word_width(VAL_W)-1:0] therm_o
);

    localparam int unsigned TW = thq_pkg::thq_word_width(VAL_W);

    logic load;
    logic last;
    logic busy;
    logic done;

    thq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .zero_i  (value_i == '0),
        .last_i  (last),
        .load_o  (load),
        .busy_o  (busy),
        .done_o  (done)
    );

    thq_count #(.VAL_W(VAL_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (busy),
        .value_i (value_i),
        .last_o  (last)
    );

    thq_shreg #(.WORD_W(TW)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .step_i  (busy),
        .word_o  (therm_o)
    );

    assign busy_o = busy;
    assign done_o = done;

endmodule

// File: rtl/thq_conv_chk.sv
module thq_conv_chk #(
    parameter int unsigned TW = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [TW-1:0] therm_o
);

    // R5: the two status flags exclude each other
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R5: done repeats only when a start was taken in the done cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o || $past(start_i)));

    // R2: an accepted start yields either a running or a finished state
    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o != done_o));

    // R3: one bit enters at the bottom per busy cycle
    a_r3_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (therm_o == TW'({$past(therm_o), 1'b1})));

    // R7: a start during a run does not clear the word
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && (therm_o != '0)) |=> (therm_o != '0));

    // R8: idle and no start means the word holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(therm_o));

    // R1: the word is always a run of ones from bit 0
    a_r1_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_o & (therm_o + TW'(1))) == '0));

    // R9: reset clears all state at the next edge
    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && (therm_o == '0)));

endmodule

bind thq_conv thq_conv_chk #(.TW(TW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .therm_o (therm_o)
);

// File: tb/sim_thq_conv.sv
module sim_thq_conv;

    localparam int unsigned VAL_W = 5;
    localparam int unsigned TW    = (1 << VAL_W) - 1;

    typedef struct {
        int          val;
        logic [TW-1:0] word;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [VAL_W-1:0] value_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [TW-1:0]    therm_o;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    int   busy_cnt = 0;

    always #4 clk = ~clk;

    thq_conv #(.VAL_W(VAL_W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .value_i (value_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .therm_o (therm_o)
    );

    function automatic logic [TW-1:0] ones(input int k);
        logic [63:0] w;
        w = (64'd1 << k) - 64'd1;
        return w[TW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: present a start for one cycle, record the expectation if it should be taken
    task automatic kick(input int v, input bit taken);
        exp_t e;
        value_i = VAL_W'(v);
        start_i = 1'b1;
        if (taken) begin
            e.val  = v;
            e.word = ones(v);
            sb_q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done;
        while (!done_o) @(negedge clk);
    endtask

    // monitor: compares finished words and latencies against the queue
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_cnt = 0;
        end else begin
            if (busy_o) busy_cnt++;
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(therm_o == e.word, "R1", "finished word",
                          64'(therm_o), 64'(e.word));
                    check(busy_cnt == e.val, "R4", "busy cycles",
                          64'(busy_cnt), 64'(e.val));
                end
                busy_cnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy_o && !done_o && therm_o == '0, "R9", "reset state",
              64'({busy_o, done_o, therm_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R4: every value, one at a time
        for (int v = 0; v <= int'(TW); v++) begin
            kick(v, 1'b1);
            wait_done();
            @(negedge clk);
        end

        // R2, R3: start after a held word clears it, then one bit per cycle
        kick(6, 1'b1);
        check(busy_o && therm_o == '0, "R2", "cleared and busy",
              64'({busy_o, therm_o}), 64'({1'b1, {TW{1'b0}}}));
        @(negedge clk);
        @(negedge clk);
        check(therm_o == ones(2), "R3", "partial fill", 64'(therm_o), 64'(ones(2)));
        wait_done();
        @(negedge clk);

        // R6: zero value
        kick(0, 1'b1);
        check(done_o && !busy_o && therm_o == '0, "R6", "zero finishes at once",
              64'({done_o, busy_o, therm_o}), 64'({1'b1, 1'b0, {TW{1'b0}}}));
        @(negedge clk);
        check(!done_o && !busy_o, "R6", "zero single pulse",
              64'({done_o, busy_o}), 0);

        // R7: start during a run is dropped
        kick(10, 1'b1);
        @(negedge clk);
        @(negedge clk);
        kick(2, 1'b0);
        check(busy_o && therm_o == ones(3), "R7", "run continues",
              64'({busy_o, therm_o}), 64'({1'b1, ones(3)}));
        wait_done();
        @(negedge clk);

        // R8: word holds while idle
        held = therm_o;
        repeat (5) @(negedge clk);
        check(therm_o == held && !busy_o && !done_o, "R8", "hold",
              64'(therm_o), 64'(held));

        // R10: back-to-back starts in the done cycle, including zero
        kick(4, 1'b1);
        wait_done();
        kick(0, 1'b1);
        check(done_o && therm_o == '0, "R10", "zero after done",
              64'({done_o, therm_o}), 64'({1'b1, {TW{1'b0}}}));
        kick(7, 1'b1);
        check(busy_o && therm_o == '0, "R10", "load after done",
              64'({busy_o, therm_o}), 64'({1'b1, {TW{1'b0}}}));
        wait_done();
        kick(int'(TW), 1'b1);
        wait_done();
        @(negedge clk);

        // R9: reset in the middle of a run
        kick(20, 1'b1);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        sb_q.delete();
        @(negedge clk);
        check(!busy_o && !done_o && therm_o == '0, "R9", "mid-run reset",
              64'({busy_o, done_o, therm_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && therm_o == '0, "R9", "quiet after reset",
              64'({busy_o, done_o, therm_o}), 0);
        check(sb_q.size() == 0, "R5", "queue drained", 64'(sb_q.size()), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule